// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block acts as the master of a microcontroller-style external bus. It runs one read or write at a time against a peripheral that shares eight bidirectional lines between the low address byte and the data byte. A host-side command carries a 16-bit address, an operation code and write data. The block first puts the low address on the shared lines and pulses the address-latch strobe. It then frees the lines for the data phase and drives the select and read/write strobes. The high address byte comes out on a dedicated eight-bit output.

A slow peripheral can stretch the strobe phase by holding the ready input low. Ready passes through a two-flop synchronizer before the state machine uses it. A third command kind does no bus access. It stalls until a chosen general-purpose input reaches a requested level, so the host can wait for a device's interrupt line and then read the device. That wait has a programmable limit. If the limit runs out, the command still finishes, and it raises an error flag.

States: `ST_IDLE`, `ST_ADDR`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD`, `ST_WAIT`, `ST_DONE`. Transitions: IDLE→ADDR when a read or write is accepted; IDLE→WAIT when a pin wait is accepted; ADDR→SETUP always; SETUP→STROBE always; STROBE→HOLD once the minimum width has passed and synchronized ready is high; HOLD→DONE always; WAIT→DONE on a pin match or on timeout; DONE→IDLE always.

Top module: `mbus_master`

## Requirements
- R1: After reset, `cmd_ready` is high. `cs_n`, `rd_n` and `wr_n` are high. `ale`, `ad_oe` and `done` are low.
- R2: Each read or write starts with exactly one clock in which `ale` is high. In that clock `ad_oe` is high, `ad_out` equals address bits 7:0, `addr_hi` equals address bits 15:8, and `cs_n`, `rd_n` and `wr_n` are all high.
- R3: `cs_n` goes low in the clock after the `ale` clock and stays low through the last strobe clock, which makes it one clock longer than the strobe. `ale` is never high while `cs_n` is low.
- R4: On a write, `ad_oe` is high and `ad_out` equals the write data in every clock in which `wr_n` is low. Both also hold in the clock just after `wr_n` rises.
- R5: On a read, `ad_oe` is low in every clock after the `ale` clock. `rdata` equals the value on `ad_in` during the last clock in which `rd_n` is low.
- R6: `rd_n` and `wr_n` are never low together. Op code 0 pulses only `rd_n`, and op code 1 pulses only `wr_n`.
- R7: With ready high, the strobe stays low for exactly `strobe_clks` clocks. A value of 0 behaves as 1.
- R8: While synchronized ready is low, the strobe stays low. When `rdy_in` rises, the strobe ends two clocks later, once the minimum width has been met.
- R9: Op code 2 causes no bus activity. Its `done` comes three clocks after `gpio_in[cmd_pin]` reaches `cmd_level`, with `tmo_err` low.
- R10: If the selected pin does not reach the requested level, the wait ends `wait_limit`+1 clocks after acceptance, with `done` and `tmo_err` high.
- R11: `done` lasts exactly one clock. `cmd_valid` is ignored while `cmd_ready` is low, so holding it high during a cycle does not start or alter an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 2 | 0 read, 1 write, 2 pin wait, 3 treated as read |
| cmd_addr | input | 16 | Access address |
| cmd_wdata | input | 8 | Write data |
| cmd_pin | input | 2 | Index of the GPIO to wait on |
| cmd_level | input | 1 | Level the pin wait waits for |
| strobe_clks | input | 4 | Minimum strobe width in clocks |
| wait_limit | input | 16 | Pin wait timeout in clocks |
| cmd_ready | output | 1 | High when idle |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last read data |
| tmo_err | output | 1 | Last pin wait timed out |
| ad_out | output | 8 | Shared bus value driven |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus value seen |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch pulse, active high |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdy_in | input | 1 | Asynchronous ready, low stretches the cycle |
| gpio_in | input | 4 | Asynchronous pins for the wait command |

## Verification
The hardest behaviour to reach is the exact end of a stretched strobe. The release of ready passes through the synchronizer, so the moment the strobe ends depends on when ready rose relative to the strobe. The bench holds `rdy_in` low before the command starts. It watches the strobe and raises ready only after a chosen number of strobe clocks. Both strobe lengths are then predictable: the chosen count plus two. The pin wait is handled the same way: the selected pin changes at a known clock, and both the completion clock and the timeout clock are pinned down exactly.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT,
        ST_DONE
    } mbus_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_PIN   = 2'd2,
        OP_RSVD  = 2'd3
    } mbus_op_e;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/mbus_cnt.sv
module mbus_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;
    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_r <= '0;
        else if (clr)
            q_r <= '0;
        else if (en && q_r != TOP)
            q_r <= q_r + 1'b1;
    end

    assign q = q_r;
endmodule

// File: rtl/mbus_master.sv
module mbus_master
    import mbus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int PIN_N    = 4,
    parameter int STROBE_W = 4,
    parameter int TMO_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [DATA_W-1:0]        cmd_wdata,
    input  logic [$clog2(PIN_N)-1:0] cmd_pin,
    input  logic                     cmd_level,
    input  logic [STROBE_W-1:0]      strobe_clks,
    input  logic [TMO_W-1:0]         wait_limit,
    output logic                     cmd_ready,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     tmo_err,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     cs_n,
    output logic                     rd_n,
    output logic                     wr_n,
    input  logic                     rdy_in,
    input  logic [PIN_N-1:0]         gpio_in
);
    localparam int CNT_W = (STROBE_W > TMO_W) ? STROBE_W : TMO_W;
    localparam int PSEL_W = $clog2(PIN_N);

    mbus_state_e state_q, state_d;

    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [PSEL_W-1:0]   pin_q;
    logic                level_q;
    logic                is_wr_q;
    logic                is_pin;
    logic [STROBE_W-1:0] strb_q;
    logic [TMO_W-1:0]    limit_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                err_q;

    logic              rdy_s;
    logic [PIN_N-1:0]  gpio_s;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W:0]    cnt_next;
    logic              cnt_clr;
    logic              width_met;
    logic              pin_hit;
    logic              limit_hit;
    logic              accept;

    mbus_sync #(.W(1)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rdy_in), .sync_o(rdy_s)
    );

    mbus_sync #(.W(PIN_N)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .async_i(gpio_in), .sync_o(gpio_s)
    );

    assign cnt_clr = (state_q != ST_STROBE) && (state_q != ST_WAIT);

    mbus_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(1'b1), .q(cnt)
    );

    assign cnt_next  = {1'b0, cnt} + 1'b1;
    assign width_met = cnt_next >= {{(CNT_W+1-STROBE_W){1'b0}}, strb_q};
    assign limit_hit = cnt_next >= {{(CNT_W+1-TMO_W){1'b0}}, limit_q};
    assign pin_hit   = gpio_s[pin_q] == level_q;
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign is_pin    = cmd_op == OP_PIN;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = is_pin ? ST_WAIT : ST_ADDR;
            ST_ADDR:   state_d = ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (width_met && rdy_s) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_DONE;
            ST_WAIT:   if (pin_hit || limit_hit) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            pin_q   <= '0;
            level_q <= 1'b0;
            is_wr_q <= 1'b0;
            strb_q  <= '0;
            limit_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= cmd_addr;
                wdata_q <= cmd_wdata;
                pin_q   <= cmd_pin;
                level_q <= cmd_level;
                is_wr_q <= cmd_op == OP_WRITE;
                strb_q  <= strobe_clks;
                limit_q <= wait_limit;
                err_q   <= 1'b0;
            end
            if (state_q == ST_STROBE && state_d == ST_HOLD && !is_wr_q)
                rdata_q <= ad_in;
            if (state_q == ST_WAIT && !pin_hit && limit_hit)
                err_q <= 1'b1;
        end
    end

    // Moore outputs
    always_comb begin
        ale    = 1'b0;
        cs_n   = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        ad_oe  = 1'b0;
        ad_out = '0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
            end
            ST_SETUP: begin
                cs_n   = 1'b0;
                ad_oe  = is_wr_q;
                ad_out = is_wr_q ? wdata_q : '0;
            end
            ST_STROBE: begin
                cs_n   = 1'b0;
                rd_n   = is_wr_q;
                wr_n   = !is_wr_q;
                ad_oe  = is_wr_q;
                ad_out = is_wr_q ? wdata_q : '0;
            end
            ST_HOLD: begin
                ad_oe  = is_wr_q;
                ad_out = is_wr_q ? wdata_q : '0;
            end
            ST_WAIT: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign cmd_ready = state_q == ST_IDLE;
    assign rdata     = rdata_q;
    assign tmo_err   = err_q;
    assign addr_hi   = addr_q[ADDR_W-1:DATA_W];

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3
    ale_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !cs_n));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale && !cs_n);

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && state_d == ST_HOLD) |=> (ad_oe && wr_n));

    // R8
    rdy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !rdy_s) |=> !rd_n);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/mbus_master_test.sv
module mbus_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic [1:0]  cmd_pin = '0;
    logic        cmd_level = 1'b0;
    logic [3:0]  strobe_clks = 4'd1;
    logic [15:0] wait_limit = 16'd100;
    logic        cmd_ready, done, tmo_err, ad_oe, ale, cs_n, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, addr_hi, ad_in;
    logic        rdy_in = 1'b1;
    logic [3:0]  gpio_in = 4'b0000;
    logic [7:0]  lat_lo = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign ad_in = rd_n ? 8'h00 : (lat_lo ^ addr_hi ^ 8'hA5);

    mbus_master uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_pin(cmd_pin),
        .cmd_level(cmd_level), .strobe_clks(strobe_clks), .wait_limit(wait_limit),
        .cmd_ready(cmd_ready), .done(done), .rdata(rdata), .tmo_err(tmo_err),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi),
        .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rdy_in(rdy_in),
        .gpio_in(gpio_in)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bus monitor results
    int  m_ale, m_ale_lo, m_ale_hi, m_ale_bad, m_cs, m_rlen, m_wlen;
    int  m_wd_bad, m_oe_bad, m_both, m_cycles, m_csale, m_done_after, m_last_rd;

    task automatic run_bus(input logic [1:0] op, input logic [15:0] a,
                           input logic [7:0] wd, input logic [3:0] n,
                           input int rel_k, input bit keep_valid);
        bit prev_wr = 1'b0;
        m_ale = 0; m_ale_lo = 0; m_ale_hi = 0; m_ale_bad = 0; m_cs = 0;
        m_rlen = 0; m_wlen = 0; m_wd_bad = 0; m_oe_bad = 0; m_both = 0;
        m_cycles = 0; m_csale = 0; m_last_rd = 0;
        strobe_clks = n;
        cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        if (rel_k > 0) rdy_in = 1'b0;
        @(negedge clk);
        if (keep_valid) cmd_addr = ~a; else cmd_valid = 1'b0;
        while (!done && m_cycles < 200) begin
            m_cycles++;
            if (ale) begin
                m_ale++; m_ale_lo = ad_out; m_ale_hi = addr_hi; lat_lo = ad_out;
                if (!cs_n || !rd_n || !wr_n || !ad_oe) m_ale_bad++;
                if (!cs_n) m_csale++;
            end
            if (!cs_n) m_cs++;
            if (!rd_n && !wr_n) m_both++;
            if (!wr_n) begin
                m_wlen++;
                if (!(ad_oe && ad_out == wd)) m_wd_bad++;
            end
            if (wr_n && prev_wr && !(ad_oe && ad_out == wd)) m_wd_bad++;
            if (!rd_n) begin m_rlen++; m_last_rd = ad_in; end
            if (op != 2'd1 && !ale && ad_oe) m_oe_bad++;
            if (rel_k > 0 && (m_rlen + m_wlen) == rel_k && !rdy_in) rdy_in = 1'b1;
            prev_wr = !wr_n;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        m_cycles++;
        @(negedge clk);
        m_done_after = done;
        rdy_in = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 cmd_ready", cmd_ready, 1);
        check("R1 strobes idle", {cs_n, rd_n, wr_n}, 3'b111);
        check("R1 ale/oe/done low", {ale, ad_oe, done}, 3'b000);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [7:0] d, input logic [3:0] n);
        int expn = (n == 0) ? 1 : n;
        run_bus(2'd1, a, d, n, 0, 1'b0);
        check("R2 one ale clock", m_ale, 1);
        check("R2 ale clean", m_ale_bad, 0);
        check("R2 low addr", m_ale_lo, a[7:0]);
        check("R2 high addr", m_ale_hi, a[15:8]);
        check("R7 write strobe width", m_wlen, expn);
        check("R3 cs width", m_cs, expn + 1);
        check("R4 write data valid", m_wd_bad, 0);
        check("R6 no read strobe on write", m_rlen, 0);
        check("R11 done one clock", m_done_after, 0);
    endtask

    task automatic t_read(input logic [15:0] a, input logic [3:0] n, input int k);
        int expn = (k > 0) ? k + 2 : ((n == 0) ? 1 : n);
        run_bus(2'd0, a, 8'h00, n, k, 1'b0);
        check("R2 one ale clock", m_ale, 1);
        check("R2 low addr", m_ale_lo, a[7:0]);
        check("R5 bus released", m_oe_bad, 0);
        check("R5 read data", rdata, a[7:0] ^ a[15:8] ^ 8'hA5);
        check("R5 data from last strobe", rdata, m_last_rd);
        if (k > 0) check("R8 stretched strobe", m_rlen, expn);
        else check("R7 read strobe width", m_rlen, expn);
        check("R6 no write strobe on read", m_wlen, 0);
        check("R6 never both", m_both, 0);
        check("R3 no ale under cs", m_csale, 0);
    endtask

    task automatic t_busy();
        run_bus(2'd1, 16'h3C5A, 8'h77, 4'd2, 0, 1'b1);
        check("R11 single access while valid held", m_ale, 1);
        check("R11 address unaltered", m_ale_lo, 8'h5A);
        check("R11 data unaltered", m_wd_bad, 0);
    endtask

    task automatic t_pin_hit();
        int c = 0;
        int bus = 0;
        gpio_in = 4'b0000;
        repeat (3) @(negedge clk);
        cmd_op = 2'd2; cmd_pin = 2'd2; cmd_level = 1'b1; wait_limit = 16'd100;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && c < 200) begin
            c++;
            if (ale || !cs_n || !rd_n || !wr_n) bus++;
            if (c == 5) gpio_in = 4'b0100;
            @(negedge clk);
        end
        c++;
        check("R9 done three clocks after pin", c, 8);
        check("R9 no error", tmo_err, 0);
        check("R9 no bus activity", bus, 0);
        gpio_in = 4'b0000;
        @(negedge clk);
    endtask

    task automatic t_pin_timeout(input int lim);
        int c = 0;
        cmd_op = 2'd2; cmd_pin = 2'd1; cmd_level = 1'b1; wait_limit = 16'(lim);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && c < 200) begin
            c++;
            @(negedge clk);
        end
        c++;
        check("R10 timeout clock", c, lim + 1);
        check("R10 error flag", tmo_err, 1);
        @(negedge clk);
        check("R11 done one clock", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(16'hA512, 8'hC3, 4'd3);
        t_write(16'h01FF, 8'h00, 4'd0);
        t_read(16'h7E81, 4'd1, 0);
        t_read(16'h1234, 4'd4, 0);
        t_read(16'hBEEF, 4'd1, 4);
        t_busy();
        t_pin_hit();
        t_pin_timeout(12);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule